// File: doc/BRIEF.md
# CAN Controller Operating-Mode Sequencer

This block owns the operating mode of a CAN-style controller. A CPU writes a 16-bit control word. From that word the block selects operation, halt, graceful reset or forced reset, enters and leaves a low-power sleep state, and chooses whether a bus-off event drops the controller into halt on its own. A status word reports the mode the controller has settled in. That report lags the real state by a few cycles, so software has to poll for it, as it would on real silicon. The protocol engine is not part of the block. It is seen only through two inputs: a bus-idle level and a one-cycle bus-off pulse. The block returns a single run enable to the engine.

The control word carries these fields:

- Bit 0: FIFO mailbox select.
- Bits [2:1]: identifier format. The value 10 means mixed.
- Bit 3: overrun (message-lost) mode.
- Bits [9:8]: mode request. 00 is operation, 01 is graceful reset, 10 is halt and 11 is forced reset.
- Bit 10: sleep.
- Bits [12:11]: bus-off recovery. The value 01 halts automatically on bus-off.

A separate bit-timing configuration word and the four mode-select bits [3:0] accept writes only while the controller is in reset.

The state machine has six states: SLEEP, RESET, HALT, OPER, RST_PEND (a graceful reset waiting for bus idle) and HALT_PEND (a halt waiting for bus idle). Its transitions are:

- Wake: SLEEP goes to RESET or HALT when the sleep bit is cleared.
- Doze: RESET or HALT goes to SLEEP when the sleep bit is set.
- Start: RESET or HALT goes to OPER on mode 00.
- Request: OPER goes to RST_PEND on mode 01, or to HALT_PEND on mode 10.
- Settle: a pending state completes at bus idle.
- Cancel: a pending state returns to OPER on mode 00.
- Force: any awake state goes to RESET on mode 11.
- Bus-off halt: OPER or HALT_PEND goes to HALT.
- Re-enter: HALT goes to RESET on mode 01 or 11.

Top module: `can_mode_seq`

## Requirements
- R1: After hardware reset the controller is in SLEEP. The control readback is 0x0500 (mode field 01, sleep bit 10 set), the status word is 0x0400 and engine_run is 0.
- R2: In SLEEP, a control write is ignored unless it clears bit 10. Clearing bit 10 wakes the controller to HALT if the stored mode field is 10, and to RESET otherwise. The mode field of that write is ignored.
- R3: Status bit 8 (reset), bit 9 (halt) and bit 10 (sleep) follow the state exactly STS_DLY clock edges after it changes (default 3). They still hold the old value on the first cycle after the change.
- R4: Writing mode 00 in RESET or HALT enters OPER. engine_run goes high on the next cycle and status bit 8 then clears.
- R5: Writing mode 01 in OPER enters RST_PEND. engine_run stays high and RESET is not entered until bus_idle is high.
- R6: Writing mode 11 in any awake state enters RESET on the next clock, whatever the level of bus_idle.
- R7: Writing mode 10 in OPER halts once bus_idle is high. Status bit 9 then sets.
- R8: A bus_off pulse in OPER enters HALT on the next clock and sets the mode field to 10, but only when control bits [12:11] are 01. With any other value the pulse has no effect.
- R9: A forced-reset write and a bus_off pulse in the same cycle lead to RESET, not HALT.
- R10: Setting bit 10 is accepted only in RESET or HALT, and the mode field of such a write is ignored. In OPER the bit is ignored and reads back 0.
- R11: Control bits [3:0] and the configuration word are written only in RESET. In every other state, writes to them leave the readback unchanged.
- R12: The suspend sequence (halt, then sleep) returns to HALT on wake. The stop sequence (forced reset, then sleep) shows status 0x0400.
- R13: Writing mode 00 in RST_PEND or HALT_PEND cancels the request and returns to OPER.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write data |
| cfg_wr | input | 1 | Bit-timing configuration write strobe |
| cfg_wdata | input | CFG_W | Bit-timing configuration write data |
| bus_idle | input | 1 | Protocol engine reports the bus is idle |
| bus_off | input | 1 | One-cycle pulse on bus-off entry |
| ctl_rdata | output | 16 | Control word readback |
| sts_rdata | output | 16 | Status word: bit 8 reset, bit 9 halt, bit 10 sleep |
| cfg_q | output | CFG_W | Held bit-timing configuration |
| engine_run | output | 1 | Protocol engine enable |

## Verification
The hardest situations to reach are those where two requests meet. One is a bus-off pulse arriving in the same cycle as a forced-reset write. Another is a graceful request cancelled while it is still held off by a busy bus. The bench reaches both by driving bus_idle low before the request and strobing bus_off and ctl_wr together on one cycle. The lagging status is checked on exact cycles after a wake-up, so both an early update and a late one show up.

// File: rtl/can_mode_pkg.sv
`timescale 1ns/1ps
package can_mode_pkg;

    typedef enum logic [2:0] {
        ST_SLEEP     = 3'd0,
        ST_RESET     = 3'd1,
        ST_HALT      = 3'd2,
        ST_OPER      = 3'd3,
        ST_RST_PEND  = 3'd4,
        ST_HALT_PEND = 3'd5
    } opmode_e;

    localparam logic [1:0] MC_RUN = 2'b00;
    localparam logic [1:0] MC_RST = 2'b01;
    localparam logic [1:0] MC_HLT = 2'b10;
    localparam logic [1:0] MC_FRC = 2'b11;

    localparam logic [1:0] BOR_AUTO_HALT = 2'b01;

    localparam int CTL_W      = 16;
    localparam int SEL_W      = 4;
    localparam int MODE_LSB   = 8;
    localparam int SLEEP_BIT  = 10;
    localparam int BOR_LSB    = 11;
    localparam int STS_RST    = 8;
    localparam int STS_HLT    = 9;
    localparam int STS_SLP    = 10;
    localparam int STS_N      = 3;

endpackage

// File: rtl/canms_fsm.sv
`timescale 1ns/1ps
module canms_fsm
    import can_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic [1:0] wr_mode,
    input  logic       wr_sleep,
    input  logic       bus_idle,
    input  logic       bus_off,
    input  logic       bor_auto,
    output opmode_e    state,
    output logic [1:0] mode_q,
    output logic       sleep_q
);

    opmode_e    nxt;
    logic [1:0] mode_nxt;
    logic       sleep_nxt;
    logic       take_sleep;
    logic       mode_wr;
    logic       frc_wr;
    logic       auto_halt;

    assign take_sleep = ctl_wr && wr_sleep && (state == ST_RESET || state == ST_HALT);
    assign mode_wr    = ctl_wr && (state != ST_SLEEP) && !take_sleep;
    assign frc_wr     = mode_wr && (wr_mode == MC_FRC);
    assign auto_halt  = bus_off && bor_auto;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_SLEEP;
            mode_q  <= MC_RST;
            sleep_q <= 1'b1;
        end else begin
            state   <= nxt;
            mode_q  <= mode_nxt;
            sleep_q <= sleep_nxt;
        end
    end

    always_comb begin
        nxt       = state;
        mode_nxt  = mode_q;
        sleep_nxt = sleep_q;
        unique case (state)
            ST_SLEEP: begin
                if (ctl_wr && !wr_sleep) begin
                    sleep_nxt = 1'b0;
                    nxt = (mode_q == MC_HLT) ? ST_HALT : ST_RESET;
                end
            end
            ST_RESET: begin
                if (take_sleep) begin
                    sleep_nxt = 1'b1;
                    nxt = ST_SLEEP;
                end else if (mode_wr) begin
                    mode_nxt = wr_mode;
                    if (wr_mode == MC_RUN)      nxt = ST_OPER;
                    else if (wr_mode == MC_HLT) nxt = ST_HALT;
                end
            end
            ST_HALT: begin
                if (take_sleep) begin
                    sleep_nxt = 1'b1;
                    nxt = ST_SLEEP;
                end else if (mode_wr) begin
                    mode_nxt = wr_mode;
                    if (wr_mode == MC_RUN)      nxt = ST_OPER;
                    else if (wr_mode != MC_HLT) nxt = ST_RESET;
                end
            end
            ST_OPER: begin
                if (frc_wr) begin
                    mode_nxt = MC_FRC;
                    nxt = ST_RESET;
                end else if (auto_halt) begin
                    mode_nxt = MC_HLT;
                    nxt = ST_HALT;
                end else if (mode_wr) begin
                    mode_nxt = wr_mode;
                    if (wr_mode == MC_RST)      nxt = ST_RST_PEND;
                    else if (wr_mode == MC_HLT) nxt = ST_HALT_PEND;
                end
            end
            ST_RST_PEND: begin
                if (frc_wr) begin
                    mode_nxt = MC_FRC;
                    nxt = ST_RESET;
                end else if (mode_wr && wr_mode == MC_RUN) begin
                    mode_nxt = MC_RUN;
                    nxt = ST_OPER;
                end else if (bus_idle) begin
                    nxt = ST_RESET;
                end
            end
            ST_HALT_PEND: begin
                if (frc_wr) begin
                    mode_nxt = MC_FRC;
                    nxt = ST_RESET;
                end else if (auto_halt) begin
                    nxt = ST_HALT;
                end else if (mode_wr && wr_mode == MC_RUN) begin
                    mode_nxt = MC_RUN;
                    nxt = ST_OPER;
                end else if (mode_wr && wr_mode == MC_RST) begin
                    mode_nxt = MC_RST;
                    nxt = ST_RST_PEND;
                end else if (bus_idle) begin
                    nxt = ST_HALT;
                end
            end
            default: begin
                nxt = ST_RESET;
            end
        endcase
    end

    // R6
    forced_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPER && ctl_wr && wr_mode == MC_FRC) |=> (state == ST_RESET));

    // R8
    auto_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPER && bus_off && bor_auto && !(ctl_wr && wr_mode == MC_FRC))
        |=> (state == ST_HALT));

    // R5
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RST_PEND && !bus_idle && !ctl_wr) |=> (state == ST_RST_PEND));

    // R10
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_SLEEP && state != ST_RESET && state != ST_HALT)
        |=> (state != ST_SLEEP));

    // R2
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && !ctl_wr) |=> (state == ST_SLEEP));

endmodule

// File: rtl/canms_ctl_regs.sv
`timescale 1ns/1ps
module canms_ctl_regs
    import can_mode_pkg::*;
#(
    parameter int CFG_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             in_reset,
    input  logic             in_sleep,
    output logic [SEL_W-1:0] sel_q,
    output logic [1:0]       bor_q,
    output logic [CFG_W-1:0] cfg_q
);

    logic unused_wbits;
    assign unused_wbits = ^{ctl_wdata[CTL_W-1:BOR_LSB+2], ctl_wdata[BOR_LSB-1:SEL_W]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (ctl_wr && in_reset) begin
            sel_q <= ctl_wdata[SEL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bor_q <= '0;
        end else if (ctl_wr && !in_sleep) begin
            bor_q <= ctl_wdata[BOR_LSB+1:BOR_LSB];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_wr && in_reset) begin
            cfg_q <= cfg_wdata;
        end
    end

    // R11
    cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_reset |=> $stable(cfg_q));

    // R11
    sel_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_reset |=> $stable(sel_q));

endmodule

// File: rtl/canms_sts_delay.sv
`timescale 1ns/1ps
module canms_sts_delay #(
    parameter int          W       = 3,
    parameter int          DLY     = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    generate
        if (DLY == 0) begin : g_pass
            assign dout = din;
        end else begin : g_pipe
            logic [W-1:0] stg [DLY];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < DLY; i++) stg[i] <= RST_VAL;
                end else begin
                    stg[0] <= din;
                    for (int i = 1; i < DLY; i++) stg[i] <= stg[i-1];
                end
            end
            assign dout = stg[DLY-1];
        end
    endgenerate

endmodule

// File: rtl/can_mode_seq.sv
`timescale 1ns/1ps
module can_mode_seq
    import can_mode_pkg::*;
#(
    parameter int CFG_W   = 24,
    parameter int STS_DLY = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [15:0]      ctl_wdata,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             bus_idle,
    input  logic             bus_off,
    output logic [15:0]      ctl_rdata,
    output logic [15:0]      sts_rdata,
    output logic [CFG_W-1:0] cfg_q,
    output logic             engine_run
);

    localparam logic [STS_N-1:0] STS_RST_VAL = 3'b100;

    opmode_e          state;
    logic [1:0]       mode_q;
    logic             sleep_q;
    logic [SEL_W-1:0] sel_q;
    logic [1:0]       bor_q;
    logic [STS_N-1:0] sts_now;
    logic [STS_N-1:0] sts_late;

    canms_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (ctl_wr),
        .wr_mode  (ctl_wdata[MODE_LSB+1:MODE_LSB]),
        .wr_sleep (ctl_wdata[SLEEP_BIT]),
        .bus_idle (bus_idle),
        .bus_off  (bus_off),
        .bor_auto (bor_q == BOR_AUTO_HALT),
        .state    (state),
        .mode_q   (mode_q),
        .sleep_q  (sleep_q)
    );

    canms_ctl_regs #(.CFG_W(CFG_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .in_reset  (state == ST_RESET),
        .in_sleep  (state == ST_SLEEP),
        .sel_q     (sel_q),
        .bor_q     (bor_q),
        .cfg_q     (cfg_q)
    );

    assign sts_now = {state == ST_SLEEP, state == ST_HALT, state == ST_RESET};

    canms_sts_delay #(.W(STS_N), .DLY(STS_DLY), .RST_VAL(STS_RST_VAL)) u_sts (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sts_now),
        .dout  (sts_late)
    );

    always_comb begin
        ctl_rdata = '0;
        ctl_rdata[SEL_W-1:0]             = sel_q;
        ctl_rdata[MODE_LSB+1:MODE_LSB]   = mode_q;
        ctl_rdata[SLEEP_BIT]             = sleep_q;
        ctl_rdata[BOR_LSB+1:BOR_LSB]     = bor_q;
        sts_rdata = '0;
        sts_rdata[STS_RST] = sts_late[0];
        sts_rdata[STS_HLT] = sts_late[1];
        sts_rdata[STS_SLP] = sts_late[2];
    end

    assign engine_run = (state == ST_OPER) || (state == ST_RST_PEND) || (state == ST_HALT_PEND);

    // R10
    sleep_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        engine_run |-> !ctl_rdata[SLEEP_BIT]);

    // R9
    frc_over_busoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (engine_run && ctl_wr && ctl_wdata[MODE_LSB+1:MODE_LSB] == MC_FRC && bus_off)
        |=> (!engine_run && ctl_rdata[MODE_LSB+1:MODE_LSB] == MC_FRC));

endmodule

// File: tb/tb_can_mode_seq.sv
`timescale 1ns/1ps
module tb_can_mode_seq;

    localparam int CFG_W = 24;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ctl_wr = 1'b0;
    logic [15:0]      ctl_wdata = '0;
    logic             cfg_wr = 1'b0;
    logic [CFG_W-1:0] cfg_wdata = '0;
    logic             bus_idle = 1'b1;
    logic             bus_off = 1'b0;
    logic [15:0]      ctl_rdata;
    logic [15:0]      sts_rdata;
    logic [CFG_W-1:0] cfg_q;
    logic             engine_run;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    can_mode_seq #(.CFG_W(CFG_W), .STS_DLY(3)) dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .bus_idle(bus_idle), .bus_off(bus_off),
        .ctl_rdata(ctl_rdata), .sts_rdata(sts_rdata), .cfg_q(cfg_q), .engine_run(engine_run)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] d);
        @(negedge clk);
        ctl_wr = 1'b1;
        ctl_wdata = d;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic wr_cfg(input logic [CFG_W-1:0] d);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic wait_sts(input string req, input logic [15:0] exp);
        for (int i = 0; i < 20; i++) begin
            if (sts_rdata == exp) break;
            @(negedge clk);
        end
        check(req, sts_rdata, exp);
    endtask

    task automatic t_reset_state;
        check("R1 ctl", ctl_rdata, 16'h0500);
        check("R1 sts", sts_rdata, 16'h0400);
        check("R1 run", engine_run, 0);
    endtask

    task automatic t_wake;
        wr(16'h0000);
        check("R2 ctl", ctl_rdata, 16'h0100);
        check("R2 run", engine_run, 0);
        check("R3 lag0", sts_rdata, 16'h0400);
        @(negedge clk);
        @(negedge clk);
        check("R3 lag2", sts_rdata, 16'h0400);
        @(negedge clk);
        check("R3 edge3", sts_rdata, 16'h0100);
    endtask

    task automatic t_config;
        wr(16'h090D);
        check("R11 sel in reset", ctl_rdata, 16'h090D);
        wr_cfg(24'hABCDE1);
        check("R11 cfg in reset", cfg_q, 24'hABCDE1);
    endtask

    task automatic t_run;
        wr(16'h080D);
        check("R4 ctl", ctl_rdata, 16'h080D);
        check("R4 run", engine_run, 1);
        wait_sts("R4 sts", 16'h0000);
        wr(16'h0802);
        check("R11 sel locked", ctl_rdata, 16'h080D);
        wr_cfg(24'h123456);
        check("R11 cfg locked", cfg_q, 24'hABCDE1);
        wr(16'h0C0D);
        check("R10 sleep ignored", ctl_rdata, 16'h080D);
        check("R10 run", engine_run, 1);
    endtask

    task automatic t_graceful;
        bus_idle = 1'b0;
        wr(16'h090D);
        check("R5 pend run", engine_run, 1);
        repeat (6) @(negedge clk);
        check("R5 pend run late", engine_run, 1);
        check("R5 pend sts", sts_rdata, 16'h0000);
        bus_idle = 1'b1;
        @(negedge clk);
        check("R5 settled", engine_run, 0);
        wait_sts("R5 sts", 16'h0100);
        wr(16'h080D);
        wait_sts("R4 back", 16'h0000);
    endtask

    task automatic t_cancel;
        bus_idle = 1'b0;
        wr(16'h090D);
        wr(16'h080D);
        bus_idle = 1'b1;
        repeat (6) @(negedge clk);
        check("R13 run", engine_run, 1);
        check("R13 ctl", ctl_rdata, 16'h080D);
        check("R13 sts", sts_rdata, 16'h0000);
    endtask

    task automatic t_forced;
        bus_idle = 1'b0;
        wr(16'h0B0D);
        check("R6 run", engine_run, 0);
        check("R6 ctl", ctl_rdata, 16'h0B0D);
        wait_sts("R6 sts", 16'h0100);
        wr(16'h080D);
        bus_idle = 1'b1;
        wait_sts("R4 back", 16'h0000);
    endtask

    task automatic t_halt;
        bus_idle = 1'b0;
        wr(16'h0A0D);
        check("R7 pend run", engine_run, 1);
        bus_idle = 1'b1;
        @(negedge clk);
        check("R7 run", engine_run, 0);
        wait_sts("R7 sts", 16'h0200);
        wr(16'h080D);
        wait_sts("R4 back", 16'h0000);
    endtask

    task automatic pulse_busoff;
        @(negedge clk);
        bus_off = 1'b1;
        @(negedge clk);
        bus_off = 1'b0;
    endtask

    task automatic t_busoff;
        pulse_busoff();
        check("R8 run", engine_run, 0);
        check("R8 ctl", ctl_rdata, 16'h0A0D);
        wait_sts("R8 sts", 16'h0200);
        wr(16'h080D);
        wr(16'h000D);
        pulse_busoff();
        check("R8 no auto", engine_run, 1);
        check("R8 no auto ctl", ctl_rdata, 16'h000D);
        wr(16'h080D);
    endtask

    task automatic t_prio;
        @(negedge clk);
        bus_off = 1'b1;
        ctl_wr = 1'b1;
        ctl_wdata = 16'h0B0D;
        @(negedge clk);
        bus_off = 1'b0;
        ctl_wr = 1'b0;
        check("R9 ctl", ctl_rdata, 16'h0B0D);
        wait_sts("R9 sts", 16'h0100);
        wr(16'h080D);
        wait_sts("R4 back", 16'h0000);
    endtask

    task automatic t_suspend;
        wr(16'h0A0D);
        wait_sts("R12 halt", 16'h0200);
        wr(16'h0E0D);
        check("R12 sleep ctl", ctl_rdata, 16'h0E0D);
        wait_sts("R12 sleep sts", 16'h0400);
        wr(16'h0A0D);
        check("R12 wake ctl", ctl_rdata, 16'h0A0D);
        wait_sts("R12 wake halt", 16'h0200);
        wr(16'h080D);
        wait_sts("R4 resume", 16'h0000);
    endtask

    task automatic t_stop;
        wr(16'h0B0D);
        wait_sts("R12 stop rst", 16'h0100);
        wr(16'h0F0D);
        check("R12 stop ctl", ctl_rdata, 16'h0F0D);
        wait_sts("R12 stop sts", 16'h0400);
        wr_cfg(24'h000777);
        check("R11 cfg in sleep", cfg_q, 24'hABCDE1);
        wr(16'h040D);
        check("R2 sleep hold", ctl_rdata, 16'h0F0D);
        check("R2 sleep run", engine_run, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_wake();
        t_config();
        t_run();
        t_graceful();
        t_cancel();
        t_forced();
        t_halt();
        t_busoff();
        t_prio();
        t_suspend();
        t_stop();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule